// File: doc/BRIEF.md
# PLL Phase Step Sequencer

This controller runs in the PLL scan-clock domain and turns one request into a series of single-increment dynamic phase shifts. A request carries a step count, a direction and a PLL counter select. The block then runs one closed-loop handshake per step. It raises the step strobe and keeps it high for a minimum number of cycles. It releases the strobe only once the PLL's done flag has been seen low. It then waits for that flag to come back high and for a minimum low gap to pass before it issues the next strobe.

The direction and counter select are registered at acceptance and held on the PLL pins for the whole run, so they are stable around every edge on which the PLL samples them. A busy flag covers the run, and a one-cycle completion pulse ends it. A programmable watchdog aborts the run and flags an error when the PLL stops answering. The step count can be any value its width allows, so long shift sequences need no help from the requester.

Top module: `phase_step_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `step_o`, `busy_o`, `done_o`, `err_o`, `updown_o` and `cntsel_o` are all 0.
- R2: A request that is accepted with step count N > 0 produces exactly N rising edges of `step_o`, provided the PLL answers every step.
- R3: Every strobe released by the normal handshake stays high for at least HOLD_MIN cycles (default 2).
- R4: A normally released strobe falls only after `pll_done` has been sampled low during that strobe.
- R5: A strobe that follows an earlier one within the same run rises only after `pll_done` was high in the previous cycle and at least GAP_MIN cycles (default 1) with `step_o` low have passed.
- R6: `updown_o` (1 = shift up, 0 = shift down) and `cntsel_o` take `req_up` and `req_sel` at acceptance and stay unchanged while `busy_o` is high.
- R7: `busy_o` rises in the cycle after acceptance and stays high until the run ends. `done_o` is high for exactly one cycle, which is the first cycle with `busy_o` low.
- R8: A request presented while `busy_o` is high is ignored. It changes neither the number of strobes nor the direction and select of the run in progress.
- R9: A request with step count 0 raises `done_o` in the next cycle. `busy_o` stays low and no strobe is issued.
- R10: Timeout. A run aborts and `done_o` and `err_o` pulse together when either of two limits is exceeded. The first is `pll_done` failing to drop within the captured `tmo_limit` cycles of the strobe rising. The second is `pll_done` failing to return high within `tmo_limit` cycles of the strobe falling. A limit of 0 disables the timeout, and the block then waits indefinitely.
- R11: `err_o` is high only together with `done_o`. A run in which the PLL answers every step ends with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_steps | input | CNT_W | Number of phase steps to perform |
| req_up | input | 1 | Direction: 1 up, 0 down |
| req_sel | input | SEL_W | PLL counter select |
| tmo_limit | input | TMO_W | Handshake timeout in cycles, 0 disables |
| pll_done | input | 1 | Done flag from the PLL, synchronous to clk |
| step_o | output | 1 | Phase step strobe to the PLL |
| updown_o | output | 1 | Direction held toward the PLL |
| cntsel_o | output | SEL_W | Counter select held toward the PLL |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set with done_o when a run aborted on timeout |

## Verification
The hardest state to reach is a stalled PLL, in both places it can stall. One stall leaves the done flag high under a held strobe. The other leaves it low after the strobe has fallen. A bench model of the PLL therefore has three selectable behaviours: normal, never drop, and never recover. The table walks through all three, with timeouts set short enough to fire and, in one directed case, disabled so that the hang can be observed. A second hard case is a request arriving in the middle of a run. It is driven between strobes of a two-step run with a different count, direction and select, and the bench then checks that the strobe count and the held pins stay as first requested.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } pss_state_e;
endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_ce;
  logic         sat;

  assign sat     = &cnt_q;
  assign cnt_ce  = clr | ~sat;
  assign cnt_n   = clr ? '0 : cnt_q + 1'b1;
  assign expired = (limit != '0) && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end

  // counter never moves backwards except on a clear
  p_count_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) && !$past(sat) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pss_step_ctrl.sv
module pss_step_ctrl
  import pss_pkg::*;
#(
  parameter int HOLD_MIN = 2,
  parameter int GAP_MIN  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       more,
  input  logic       pll_done,
  input  logic       tmo_hit,
  output pss_state_e state_o,
  output logic       step_o,
  output logic       fin_o,
  output logic       abort_o,
  output logic       tmr_clr_o
);
  localparam int LIM = (HOLD_MIN > GAP_MIN) ? HOLD_MIN : GAP_MIN;
  localparam int AW  = $clog2(LIM + 1);

  pss_state_e    state_q, state_n;
  logic [AW-1:0] age_q, age_n, age_inc;
  logic          seen_q, seen_n;
  logic          low_now, hold_ok, gap_ok;

  assign age_inc = (age_q == AW'(LIM)) ? age_q : age_q + 1'b1;
  assign low_now = seen_q | ~pll_done;
  assign hold_ok = age_q >= AW'(HOLD_MIN - 1);
  assign gap_ok  = age_q >= AW'(GAP_MIN - 1);

  always_comb begin
    state_n = state_q;
    age_n   = age_inc;
    seen_n  = seen_q;
    fin_o   = 1'b0;
    abort_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        age_n  = '0;
        seen_n = 1'b0;
        if (go) state_n = ST_PULSE;
      end
      ST_PULSE: begin
        seen_n = low_now;
        if (low_now && hold_ok) begin
          state_n = ST_WAIT;
          age_n   = '0;
          seen_n  = 1'b0;
        end else if (tmo_hit && !low_now) begin
          state_n = ST_IDLE;
          abort_o = 1'b1;
        end
      end
      ST_WAIT: begin
        seen_n = 1'b0;
        if (pll_done && gap_ok) begin
          fin_o   = 1'b1;
          age_n   = '0;
          state_n = more ? ST_PULSE : ST_IDLE;
        end else if (tmo_hit && !pll_done) begin
          state_n = ST_IDLE;
          abort_o = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      age_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      age_q   <= age_n;
      seen_q  <= seen_n;
    end
  end

  assign state_o   = state_q;
  assign step_o    = (state_q == ST_PULSE);
  assign tmr_clr_o = (state_n != state_q) || (state_q == ST_IDLE);

  // independent observers of the strobe for the assertions below
  logic [7:0] chk_hi_q;
  logic       chk_low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hi_q  <= '0;
      chk_low_q <= 1'b0;
    end else begin
      chk_hi_q  <= step_o ? ((&chk_hi_q) ? chk_hi_q : chk_hi_q + 1'b1) : '0;
      chk_low_q <= step_o & (chk_low_q | ~pll_done);
    end
  end

  p_hold_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_o) && state_o == ST_WAIT |-> chk_hi_q >= 8'(HOLD_MIN));

  p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_o) && state_o == ST_WAIT |-> chk_low_q);

  p_rise_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_o) && $past(state_o) == ST_WAIT |-> $past(pll_done));
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
  import pss_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int TMO_W    = 16,
  parameter int HOLD_MIN = 2,
  parameter int GAP_MIN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_steps,
  input  logic             req_up,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             pll_done,
  output logic             step_o,
  output logic             updown_o,
  output logic [SEL_W-1:0] cntsel_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pss_state_e       state;
  logic             fin, abort, tmr_clr, tmo_hit, more;
  logic             accept, zero_req, go;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             rem_ce;
  logic             dir_q;
  logic [SEL_W-1:0] sel_q;
  logic [TMO_W-1:0] lim_q;
  logic             done_q, done_n, err_q, err_n;

  assign accept   = req_valid && (state == ST_IDLE);
  assign zero_req = accept && (req_steps == '0);
  assign go       = accept && (req_steps != '0);
  assign more     = (rem_q != CNT_W'(1));

  always_comb begin
    rem_n  = rem_q;
    rem_ce = 1'b0;
    if (go) begin
      rem_n  = req_steps;
      rem_ce = 1'b1;
    end else if (fin) begin
      rem_n  = rem_q - 1'b1;
      rem_ce = 1'b1;
    end
    done_n = zero_req | (fin & ~more) | abort;
    err_n  = abort;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rem_q  <= '0;
      dir_q  <= 1'b0;
      sel_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rem_ce) rem_q <= rem_n;
      if (go) begin
        dir_q <= req_up;
        sel_q <= req_sel;
        lim_q <= tmo_limit;
      end
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  pss_step_ctrl #(.HOLD_MIN(HOLD_MIN), .GAP_MIN(GAP_MIN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .go       (go),
    .more     (more),
    .pll_done (pll_done),
    .tmo_hit  (tmo_hit),
    .state_o  (state),
    .step_o   (step_o),
    .fin_o    (fin),
    .abort_o  (abort),
    .tmr_clr_o(tmr_clr)
  );

  pss_timer #(.W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr    (tmr_clr),
    .limit  (lim_q),
    .expired(tmo_hit)
  );

  assign busy_o   = (state != ST_IDLE);
  assign updown_o = dir_q;
  assign cntsel_o = sel_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o && $past(busy_o) |-> $stable(updown_o) && $stable(cntsel_o));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy_o) |-> done_o);

  p_zero_req_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid && !busy_o && req_steps == '0 |=> done_o && !busy_o);

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_o |-> done_o);
endmodule

// File: tb/phase_step_seq_test.sv
module phase_step_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_steps = '0;
  logic        req_up = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [15:0] tmo_limit = '0;
  logic        pll_done;
  logic        step_o, updown_o, busy_o, done_o, err_o;
  logic [2:0]  cntsel_o;

  always #4 clk = ~clk;  // 125 MHz

  phase_step_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_steps(req_steps),
    .req_up(req_up), .req_sel(req_sel), .tmo_limit(tmo_limit),
    .pll_done(pll_done), .step_o(step_o), .updown_o(updown_o),
    .cntsel_o(cntsel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // PLL model: mode 0 normal, 1 never drops done, 2 never raises it again
  logic [1:0] mdl_mode = 2'd0;
  logic [7:0] mdl_low = 8'd1;
  logic       mdl_clr = 1'b0;
  logic [7:0] hi_edges, low_left;
  logic       answered;
  always @(posedge clk) begin
    if (!rst_n || mdl_clr) begin
      pll_done <= 1'b1; hi_edges <= '0; low_left <= '0; answered <= 1'b0;
    end else begin
      hi_edges <= step_o ? hi_edges + 8'd1 : 8'd0;
      if (!step_o) answered <= 1'b0;
      if (low_left != 8'd0) begin
        low_left <= low_left - 8'd1;
        if (low_left == 8'd1 && mdl_mode != 2'd2) pll_done <= 1'b1;
      end else if (step_o && hi_edges == 8'd1 && !answered && mdl_mode != 2'd1) begin
        pll_done <= 1'b0; low_left <= mdl_low; answered <= 1'b1;
      end
    end
  end

  // monitor on falling edges
  int rises = 0, hi_run = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0;
  bit prev_step = 0, prev_done = 1, saw_low = 0, first_rise = 1;
  logic [1:0] cur_mode = 2'd0;
  logic       exp_up = 1'b0;
  logic [2:0] exp_sel = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_o && !prev_step) begin
        rises++;
        if (!first_rise && !prev_done) v_r5++;
        first_rise = 0;
      end
      if (step_o) begin
        hi_run++;
        if (!pll_done) saw_low = 1;
      end
      if (!step_o && prev_step) begin
        if (cur_mode == 2'd0) begin
          if (hi_run < 2) v_r3++;
          if (!saw_low) v_r4++;
        end
        hi_run = 0; saw_low = 0;
      end
      if (busy_o && (updown_o != exp_up || cntsel_o != exp_sel)) v_r6++;
      prev_step = step_o; prev_done = pll_done;
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic prep(input logic [1:0] mode, input logic [7:0] lowlen,
                      input logic up, input logic [2:0] sel);
    mdl_mode = mode; mdl_low = lowlen; cur_mode = mode;
    exp_up = up; exp_sel = sel;
    mdl_clr = 1'b1; tick(); mdl_clr = 1'b0; tick();
    rises = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; first_rise = 1;
  endtask

  task automatic issue(input logic [15:0] st, input logic up,
                       input logic [2:0] sel, input logic [15:0] tmo);
    req_steps = st; req_up = up; req_sel = sel; tmo_limit = tmo;
    req_valid = 1'b1; tick(); req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen, output bit err);
    seen = 0; err = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done_o) begin seen = 1; err = err_o; break; end
      tick();
    end
  endtask

  typedef struct packed {
    logic [15:0] steps;
    logic        up;
    logic [2:0]  sel;
    logic [7:0]  lowlen;
    logic [1:0]  mode;
    logic [15:0] tmo;
    logic        err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd1,  1'b1, 3'd2, 8'd1, 2'd0, 16'd0,  1'b0},
    '{16'd3,  1'b0, 3'd5, 8'd4, 2'd0, 16'd20, 1'b0},
    '{16'd40, 1'b1, 3'd7, 8'd2, 2'd0, 16'd0,  1'b0},
    '{16'd2,  1'b1, 3'd3, 8'd3, 2'd1, 16'd12, 1'b1},
    '{16'd2,  1'b0, 3'd4, 8'd3, 2'd2, 16'd12, 1'b1},
    '{16'd5,  1'b0, 3'd1, 8'd1, 2'd0, 16'd4,  1'b0}
  };

  initial begin
    bit seen, err;
    int exp_rises;
    repeat (3) tick();
    check(!step_o && !busy_o && !done_o && !err_o && !updown_o && cntsel_o == 0,
          "R1 in reset", {step_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    tick();
    check(!step_o && !busy_o && !done_o && !err_o, "R1 after release",
          {step_o, busy_o, done_o, err_o}, 0);
    repeat (3) tick();

    foreach (VECS[k]) begin
      prep(VECS[k].mode, VECS[k].lowlen, VECS[k].up, VECS[k].sel);
      issue(VECS[k].steps, VECS[k].up, VECS[k].sel, VECS[k].tmo);
      check(busy_o, "R7 busy after accept", busy_o, 1);
      wait_done(seen, err);
      check(seen && !busy_o, "R7 done ends run", {seen, busy_o}, 2);
      exp_rises = (VECS[k].mode == 2'd0) ? int'(VECS[k].steps) : 1;
      check(rises == exp_rises, "R2 strobe count", rises, exp_rises);
      check(err == VECS[k].err, "R10 R11 error flag", err, VECS[k].err);
      check(v_r3 == 0, "R3 strobe hold", v_r3, 0);
      check(v_r4 == 0, "R4 release after low", v_r4, 0);
      check(v_r5 == 0, "R5 rise after done high", v_r5, 0);
      check(v_r6 == 0, "R6 held direction/select", v_r6, 0);
      tick();
      check(!done_o && !err_o, "R7 single done pulse", done_o, 0);
    end

    // R9: zero step count
    prep(2'd0, 8'd1, 1'b0, 3'd0);
    issue(16'd0, 1'b1, 3'd6, 16'd0);
    check(done_o && !busy_o && !err_o, "R9 zero completes", {done_o, busy_o}, 2);
    tick();
    check(!done_o && rises == 0, "R9 no strobe", rises, 0);

    // R8: request during a run is ignored
    prep(2'd0, 8'd5, 1'b1, 3'd1);
    issue(16'd2, 1'b1, 3'd1, 16'd0);
    repeat (6) tick();
    issue(16'd7, 1'b0, 3'd6, 16'd3);
    wait_done(seen, err);
    check(seen && !err, "R8 run completes normally", {seen, err}, 2);
    check(rises == 2, "R8 strobe count unchanged", rises, 2);
    check(v_r6 == 0, "R8 direction unchanged", v_r6, 0);
    tick();

    // R10: a limit of 0 disables the timeout, so the run hangs
    prep(2'd1, 8'd1, 1'b1, 3'd2);
    issue(16'd1, 1'b1, 3'd2, 16'd0);
    repeat (300) tick();
    check(busy_o && step_o && !done_o, "R10 disabled timeout waits",
          {busy_o, step_o, done_o}, 6);
    rst_n = 1'b0;
    tick();
    check(!busy_o && !step_o && !updown_o, "R1 reset mid-run",
          {busy_o, step_o, updown_o}, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule